// File: doc/BRIEF.md
# PPS-Aligned Seconds/Ticks Timekeeper

This block keeps a 64-bit notion of time. The upper half is a seconds count and the lower half is a ticks count. The ticks count advances once per clock. When it reaches a programmable ticks-per-second limit, it wraps to zero and the seconds count steps up by one.

Software sets the time in two steps. First it writes the seconds and ticks values it wants into shadow registers. Then it arms a load. An armed load is applied either at once or on the next active edge of a pulse-per-second signal. That signal is taken from one of two external inputs. The choice of input and the active polarity both come from a flag register. The selected input is synchronized before its edge is detected.

All writes arrive through a single-cycle strobe carrying a register select code and a 32-bit data word. The register select codes are 0 seconds shadow, 1 ticks shadow, 2 flags, 3 arm, 4 ticks-per-second.

Top module: `pps_timekeeper`

## Requirements
- R1: Reset does the following:
  - sets seconds and ticks to 0;
  - drops any armed load;
  - restores the flags to falling edge on input A;
  - restores ticks-per-second to its parameter default.
- R2: In a cycle with no load applied and no wrap, ticks increases by exactly 1 and seconds holds.
- R3: A cycle in which ticks is at or above ticks-per-second minus 1 wraps. At the next clock edge ticks becomes 0 and seconds increases by 1.
- R4: A write to the arm register (select 3) with data bit 0 set copies the seconds shadow (select 0) and the ticks shadow (select 1) onto the outputs at that same clock edge. It leaves no load pending.
- R5: A write to the arm register with data bit 0 clear sets the pending output. The load then waits for the selected PPS edge. It is applied at the third clock edge after the input changes: two synchronizer flops, then edge detection. With flags bit 0 clear, only a falling edge counts.
- R6: With flags (select 2) bit 0 set, only a rising edge of the selected input applies a pending load.
- R7: With flags bit 1 set, the PPS source is input B and edges on input A have no effect. With bit 1 clear, the source is input A.
- R8: A pending load is applied exactly once and the pending output then clears. If a PPS edge falls in the same cycle as an arm write, that edge is ignored and the load stays pending.
- R9: In a cycle where a load is applied, the loaded values take priority over the wrap and over the tick increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; ticks advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Single-cycle register write strobe |
| cfg_sel | input | 3 | Register select code for the write |
| cfg_data | input | 32 | Write data |
| pps_a | input | 1 | First external pulse-per-second input |
| pps_b | input | 1 | Second external pulse-per-second input |
| time_secs | output | 32 | Current seconds count |
| time_ticks | output | 32 | Current ticks count |
| load_pending | output | 1 | High while an armed load waits for a PPS edge |

## Verification
Some rules are checked by the checker's properties on every cycle:
- the plain tick increment;
- the wrap into seconds;
- the value a fired load leaves behind;
- the pending flag being set by an arm, held until an edge, and cleared by the fire.

Other behaviour only the bench scenarios can show:
- the three-edge latency from a PPS transition to the load;
- the polarity and source selection;
- that the wrong edge or the unselected input is ignored;
- that the load is not repeated on later pulses;
- that an edge colliding with an arm write is discarded;
- that reset restores the default flags.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_SECS  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_TICKS = 3'd1;
  localparam logic [SEL_W-1:0] SEL_FLAGS = 3'd2;
  localparam logic [SEL_W-1:0] SEL_ARM   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_TPS   = 3'd4;

  // bit 1: take input B, bit 0: rising edge active
  typedef struct packed {
    logic src_b;
    logic rise;
  } tk_flags_t;

  localparam tk_flags_t FLAGS_DEFAULT = '{src_b: 1'b0, rise: 1'b0};
endpackage

// File: rtl/tk_pps_sync.sv
module tk_pps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_a,
  input  logic pps_b,
  input  logic src_b,
  input  logic rise,
  output logic pps_edge
);
  logic raw;
  logic [STAGES-1:0] sync_q;
  logic prev_q;
  logic synced;

  assign raw = src_b ? pps_b : pps_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= raw;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign pps_edge = rise ? (synced & ~prev_q) : (~synced & prev_q);
endmodule

// File: rtl/tk_load_ctrl.sv
module tk_load_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic arm_imm,
  input  logic pps_edge,
  output logic load_fire,
  output logic load_pending
);
  logic pend_q;

  // an arm write wins over an edge landing in the same cycle
  assign load_fire = (arm_wr & arm_imm) | (pend_q & pps_edge & ~arm_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (arm_wr)    pend_q <= ~arm_imm;
    else if (load_fire) pend_q <= 1'b0;
  end

  assign load_pending = pend_q;
endmodule

// File: rtl/tk_counters.sv
module tk_counters #(
  parameter int SECS_W  = 32,
  parameter int TICKS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_fire,
  input  logic [SECS_W-1:0]  ld_secs,
  input  logic [TICKS_W-1:0] ld_ticks,
  input  logic [TICKS_W-1:0] tps,
  output logic               at_wrap,
  output logic [SECS_W-1:0]  secs,
  output logic [TICKS_W-1:0] ticks
);
  localparam logic [TICKS_W-1:0] ONE_T = TICKS_W'(1);
  localparam logic [SECS_W-1:0]  ONE_S = SECS_W'(1);

  function automatic logic last_tick(input logic [TICKS_W-1:0] t,
                                     input logic [TICKS_W-1:0] limit);
    return t >= (limit - ONE_T);
  endfunction

  logic [SECS_W-1:0]  secs_q;
  logic [TICKS_W-1:0] ticks_q;

  assign at_wrap = last_tick(ticks_q, tps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      ticks_q <= '0;
    end else if (load_fire) begin
      secs_q  <= ld_secs;
      ticks_q <= ld_ticks;
    end else if (at_wrap) begin
      secs_q  <= secs_q + ONE_S;
      ticks_q <= '0;
    end else begin
      ticks_q <= ticks_q + ONE_T;
    end
  end

  assign secs  = secs_q;
  assign ticks = ticks_q;
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
  import tk_pkg::*;
#(
  parameter int          SECS_W      = 32,
  parameter int          TICKS_W     = 32,
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned TPS_RESET   = 100_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [DATA_W-1:0]  cfg_data,
  input  logic               pps_a,
  input  logic               pps_b,
  output logic [SECS_W-1:0]  time_secs,
  output logic [TICKS_W-1:0] time_ticks,
  output logic               load_pending
);
  localparam logic [TICKS_W-1:0] TPS_INIT = TICKS_W'(TPS_RESET);

  logic [SECS_W-1:0]  shadow_secs;
  logic [TICKS_W-1:0] shadow_ticks;
  logic [TICKS_W-1:0] tps_q;
  tk_flags_t          flags_q;

  logic arm_wr;
  logic arm_imm;
  logic pps_edge;
  logic load_fire;
  logic at_wrap;

  assign arm_wr  = cfg_wr && (cfg_sel == SEL_ARM);
  assign arm_imm = cfg_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_secs  <= '0;
      shadow_ticks <= '0;
      tps_q        <= TPS_INIT;
      flags_q      <= FLAGS_DEFAULT;
    end else if (cfg_wr) begin
      case (cfg_sel)
        SEL_SECS:  shadow_secs  <= cfg_data[SECS_W-1:0];
        SEL_TICKS: shadow_ticks <= cfg_data[TICKS_W-1:0];
        SEL_FLAGS: flags_q      <= tk_flags_t'(cfg_data[1:0]);
        SEL_TPS:   tps_q        <= cfg_data[TICKS_W-1:0];
        default:   ;
      endcase
    end
  end

  tk_pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pps_a    (pps_a),
    .pps_b    (pps_b),
    .src_b    (flags_q.src_b),
    .rise     (flags_q.rise),
    .pps_edge (pps_edge)
  );

  tk_load_ctrl u_load (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_wr       (arm_wr),
    .arm_imm      (arm_imm),
    .pps_edge     (pps_edge),
    .load_fire    (load_fire),
    .load_pending (load_pending)
  );

  tk_counters #(.SECS_W(SECS_W), .TICKS_W(TICKS_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_fire (load_fire),
    .ld_secs   (shadow_secs),
    .ld_ticks  (shadow_ticks),
    .tps       (tps_q),
    .at_wrap   (at_wrap),
    .secs      (time_secs),
    .ticks     (time_ticks)
  );
endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
  parameter int SECS_W  = 32,
  parameter int TICKS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm_wr,
  input logic               arm_imm,
  input logic               pps_edge,
  input logic               load_fire,
  input logic               load_pending,
  input logic               at_wrap,
  input logic [SECS_W-1:0]  ld_secs,
  input logic [TICKS_W-1:0] ld_ticks,
  input logic [SECS_W-1:0]  time_secs,
  input logic [TICKS_W-1:0] time_ticks
);
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fire && !at_wrap) |=>
      (time_ticks == $past(time_ticks) + TICKS_W'(1)) && $stable(time_secs));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (at_wrap && !load_fire) |=>
      (time_ticks == '0) && (time_secs == $past(time_secs) + SECS_W'(1)));

  a_r4_imm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && arm_imm) |=> !load_pending && (time_secs == $past(ld_secs)));

  a_r5_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && !arm_imm) |=> load_pending);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pending && !pps_edge && !arm_wr) |=> load_pending);

  a_r8_once: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && !arm_wr) |=> !load_pending);

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (time_secs == $past(ld_secs)) && (time_ticks == $past(ld_ticks)));
endmodule

bind pps_timekeeper tk_checker #(.SECS_W(SECS_W), .TICKS_W(TICKS_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm_wr       (arm_wr),
  .arm_imm      (arm_imm),
  .pps_edge     (pps_edge),
  .load_fire    (load_fire),
  .load_pending (load_pending),
  .at_wrap      (at_wrap),
  .ld_secs      (shadow_secs),
  .ld_ticks     (shadow_ticks),
  .time_secs    (time_secs),
  .time_ticks   (time_ticks)
);

// File: tb/pps_timekeeper_tb_top.sv
module pps_timekeeper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_data;
  logic        pps_a, pps_b;
  logic [31:0] time_secs, time_ticks;
  logic        load_pending;

  always #2 clk = ~clk;

  pps_timekeeper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .pps_a(pps_a), .pps_b(pps_b),
    .time_secs(time_secs), .time_ticks(time_ticks),
    .load_pending(load_pending)
  );

  typedef struct {
    logic [31:0] s;
    logic [31:0] t;
    logic        p;
    bit          full;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // monitor: each queued item is due just after the next rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if ((load_pending !== e.p) ||
            (e.full && ((time_secs !== e.s) || (time_ticks !== e.t)))) begin
          bad++;
          if (e.full)
            $display("FAIL %s: secs=%0d ticks=%0d pend=%0b expected secs=%0d ticks=%0d pend=%0b",
                     e.tag, time_secs, time_ticks, load_pending, e.s, e.t, e.p);
          else
            $display("FAIL %s: pend=%0b expected pend=%0b", e.tag, load_pending, e.p);
        end
      end
    end
  end

  task automatic push(input logic [31:0] s, input logic [31:0] t, input logic p,
                      input bit full, input string tag);
    exp_t e;
    e.s = s; e.t = t; e.p = p; e.full = full; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic [31:0] s, input logic [31:0] t, input logic p,
                      input string tag);
    push(s, t, p, 1'b1, tag);
    @(negedge clk);
  endtask

  task automatic stepp(input logic p, input string tag);
    push(0, 0, p, 1'b0, tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic arm_go(input logic imm);
    cfg_wr = 1'b1; cfg_sel = 3'd3; cfg_data = {31'd0, imm};
  endtask

  task automatic idle();
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run incomplete actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_data = '0;
    pps_a = 1'b0; pps_b = 1'b0;
    @(negedge clk); @(negedge clk);
    push(0, 0, 1'b0, 1'b1, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 0, "R2"); step(0, 2, 0, "R2"); step(0, 3, 0, "R2");

    // R4 immediate load
    wr(3'd4, 1000);
    wr(3'd0, 7); wr(3'd1, 3);
    arm_go(1'b1); step(7, 3, 0, "R4"); idle();
    step(7, 4, 0, "R2");

    // R5 next-PPS, default falling edge on A
    wr(3'd0, 100); wr(3'd1, 50);
    arm_go(1'b0); stepp(1, "R5 armed"); idle();
    pps_a = 1'b1;
    repeat (5) stepp(1, "R5 rising ignored");
    pps_a = 1'b0;
    stepp(1, "R5"); stepp(1, "R5");
    step(100, 50, 0, "R5 fall load");
    for (int i = 1; i <= 12; i++) begin
      if (i == 2) pps_a = 1'b1;
      if (i == 6) pps_a = 1'b0;
      step(100, 50 + i, 0, "R8 no reload");
    end

    // R8 edge colliding with arm write is ignored
    pps_a = 1'b1;
    repeat (4) @(negedge clk);
    pps_a = 1'b0;
    @(negedge clk); @(negedge clk);
    arm_go(1'b0); stepp(1, "R8 collide"); idle();
    repeat (3) stepp(1, "R8 still pending");
    pps_a = 1'b1;
    repeat (3) stepp(1, "R8");
    pps_a = 1'b0;
    stepp(1, "R8"); stepp(1, "R8");
    step(100, 50, 0, "R8 later edge load");
    step(100, 51, 0, "R2");

    // R6 rising edge
    wr(3'd2, 32'd1); wr(3'd0, 200); wr(3'd1, 9);
    arm_go(1'b0); stepp(1, "R6 armed"); idle();
    repeat (2) stepp(1, "R6");
    pps_a = 1'b1;
    stepp(1, "R6"); stepp(1, "R6");
    step(200, 9, 0, "R6 rise load");
    step(200, 10, 0, "R6");

    // R7 source B
    pps_a = 1'b0;
    repeat (4) @(negedge clk);
    wr(3'd2, 32'd3); wr(3'd0, 300); wr(3'd1, 0);
    arm_go(1'b0); stepp(1, "R7 armed"); idle();
    pps_a = 1'b1;
    repeat (6) stepp(1, "R7 input A ignored");
    pps_b = 1'b1;
    stepp(1, "R7"); stepp(1, "R7");
    step(300, 0, 0, "R7 B load");
    step(300, 1, 0, "R7");

    // R3 wrap and R9 load priority
    wr(3'd4, 5); wr(3'd0, 7); wr(3'd1, 3);
    arm_go(1'b1); step(7, 3, 0, "R4"); idle();
    cfg_wr = 1'b1; cfg_sel = 3'd0; cfg_data = 50;
    step(7, 4, 0, "R2");
    arm_go(1'b1); step(50, 3, 0, "R9 load over wrap"); idle();
    step(50, 4, 0, "R2");
    step(51, 0, 0, "R3 wrap");
    step(51, 1, 0, "R3");

    // R1 mid-run reset restores default flags
    rst_n = 1'b0;
    push(0, 0, 1'b0, 1'b1, "R1 reset again");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 0, "R1");
    wr(3'd0, 5); wr(3'd1, 6);
    arm_go(1'b0); stepp(1, "R1 armed"); idle();
    repeat (4) stepp(1, "R1 rising ignored");
    pps_a = 1'b0;
    stepp(1, "R1"); stepp(1, "R1");
    step(5, 6, 0, "R1 default falling on A");
    step(5, 7, 0, "R1");

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule